// File: doc/BRIEF.md
# Pipeline Interlock and Operand Bypass Controller

This block is the hazard controller of a five-stage in-order pipeline with the stages fetch, decode, execute, memory and writeback, in that order. It looks at the register numbers, write enables and load flags of the instructions in decode, execute, memory and writeback. From these it decides when the front of the pipeline must wait, and where the two execute-stage operands are taken from. The datapath, the ALU, the register file and branch target logic sit outside it.

A single mode input picks between two operating styles. With bypassing off, a consumer waits in decode until its producer reaches writeback. With bypassing on, execute operands are taken from the execute/memory or memory/writeback pipeline registers. Only a load feeding the very next instruction still costs a wait cycle. The register file writes early in a cycle and reads late, so a producer in writeback never holds up decode. Every branch in decode costs exactly one inserted bubble, whatever its outcome.

When the block stalls, the surrounding datapath freezes the PC and the fetch/decode register. It also loads a bubble, with every write and memory enable cleared, into the decode/execute register.

Top module: `hz_stall_ctrl`

## Requirements
- R1: Out of reset, with no branch in decode and no write-enabled instruction in execute or memory, `hold_o` and `bubble_o` are 0 and both bypass selects are 2'b00.
- R2: With bypassing off, a used decode source equal to the nonzero destination of a write-enabled instruction in execute or in memory raises `hold_o`. A producer in execute therefore costs two stall cycles and one in memory costs one.
- R3: A write-enabled instruction in writeback never causes a stall, in either mode.
- R4: With bypassing on, a data stall happens only when the instruction in execute is a load whose nonzero destination matches a used decode source; a non-load producer in execute causes none.
- R5: Register 0 never creates a dependence: it neither stalls decode nor selects a bypass.
- R6: Bypass select encoding per execute operand: 2'b10 takes the execute/memory register (instruction in memory), 2'b01 takes the memory/writeback register (instruction in writeback), 2'b00 takes the register file. When both match, 2'b10 wins.
- R7: With bypassing off, both bypass selects stay at 2'b00.
- R8: A branch in decode is held for exactly one cycle once it has no pending data stall. Any data stall comes first and the single branch cycle follows it.
- R9: `bubble_o` is high in exactly the cycles in which `hold_o` is high.
- R10: The ten-instruction load/add/sub/branch sequence takes 20 cycles with 7 stalls (decode holding the 4th, 4th, 6th, 6th, 10th, 10th, 10th instruction) with bypassing off. With bypassing on it takes 16 cycles with 3 stalls (4th, 6th, 10th). Cycles are counted from the first instruction in decode to the last in writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fwd_en_i | input | 1 | 1 = bypassing on, 0 = bypassing off |
| id_src_a_i | input | REG_AW | First source register of the decode instruction |
| id_src_b_i | input | REG_AW | Second source register of the decode instruction |
| id_use_a_i | input | 1 | First decode source is read |
| id_use_b_i | input | 1 | Second decode source is read |
| id_branch_i | input | 1 | Decode instruction is a branch |
| ex_src_a_i | input | REG_AW | First source register of the execute instruction |
| ex_src_b_i | input | REG_AW | Second source register of the execute instruction |
| ex_dst_i | input | REG_AW | Destination of the execute instruction |
| ex_wen_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_dst_i | input | REG_AW | Destination of the memory-stage instruction |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| wb_dst_i | input | REG_AW | Destination of the writeback instruction |
| wb_wen_i | input | 1 | Writeback instruction writes a register |
| hold_o | output | 1 | Freeze PC and fetch/decode register |
| bubble_o | output | 1 | Load a cleared bubble into decode/execute |
| fwd_a_o | output | 2 | Bypass select for execute operand A |
| fwd_b_o | output | 2 | Bypass select for execute operand B |

## Verification
The bench targets the boundary between execute, memory and writeback producers. A design that counted writeback as a hazard would add a third stall per dependence. One that ignored the memory stage would let a consumer read a stale value after one stall. It drives register 0 as destination and source, where a careless compare would stall or bypass on nothing. It drives two producers of the same register, where a wrong priority would feed execute the older value. Branches are tried alone and behind a data stall: a missing branch flag would loop forever or never stall, and a flag that is not cleared would swallow the next branch's bubble. The full loop in both modes pins down the cycle counts and the exact instructions held.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Source choice for one execute-stage operand.
  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_MEMWB = 2'b01,
    FWD_EXMEM = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/hz_src_check.sv
// Hazard detection for one decode-stage source operand.
module hz_src_check #(
  parameter int unsigned REG_AW = 5
) (
  input  logic              fwd_en_i,
  input  logic [REG_AW-1:0] src_i,
  input  logic              use_i,
  input  logic [REG_AW-1:0] ex_dst_i,
  input  logic              ex_wen_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] mem_dst_i,
  input  logic              mem_wen_i,
  output logic              hazard_o
);

  logic live_src;
  logic hit_ex;
  logic hit_mem;

  always_comb begin
    live_src = use_i && (src_i != '0);
    hit_ex   = live_src && ex_wen_i  && (ex_dst_i  == src_i);
    hit_mem  = live_src && mem_wen_i && (mem_dst_i == src_i);
    if (fwd_en_i) begin
      hazard_o = hit_ex && ex_load_i;
    end else begin
      hazard_o = hit_ex || hit_mem;
    end
  end

endmodule

// File: rtl/hz_fwd_pick.sv
// Bypass source selection for one execute-stage operand.
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              fwd_en_i,
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] mem_dst_i,
  input  logic              mem_wen_i,
  input  logic [REG_AW-1:0] wb_dst_i,
  input  logic              wb_wen_i,
  output fwd_sel_e          sel_o
);

  always_comb begin
    sel_o = FWD_RF;
    if (fwd_en_i && (src_i != '0)) begin
      if (mem_wen_i && (mem_dst_i == src_i)) begin
        sel_o = FWD_EXMEM;
      end else if (wb_wen_i && (wb_dst_i == src_i)) begin
        sel_o = FWD_MEMWB;
      end
    end
  end

endmodule

// File: rtl/hz_branch_gate.sv
// One-bubble branch interlock: remembers that the branch in decode has
// already paid its stall cycle.
module hz_branch_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic branch_i,
  input  logic data_hz_i,
  output logic br_hz_o
);

  logic paid_q;
  logic paid_d;

  always_comb begin
    br_hz_o = branch_i && !paid_q && !data_hz_i;
    paid_d  = paid_q;
    if (!(data_hz_i || br_hz_o)) begin
      paid_d = 1'b0;
    end else if (br_hz_o) begin
      paid_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paid_q <= 1'b0;
    end else begin
      paid_q <= paid_d;
    end
  end

endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwd_en_i,
  input  logic [REG_AW-1:0] id_src_a_i,
  input  logic [REG_AW-1:0] id_src_b_i,
  input  logic              id_use_a_i,
  input  logic              id_use_b_i,
  input  logic              id_branch_i,
  input  logic [REG_AW-1:0] ex_src_a_i,
  input  logic [REG_AW-1:0] ex_src_b_i,
  input  logic [REG_AW-1:0] ex_dst_i,
  input  logic              ex_wen_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] mem_dst_i,
  input  logic              mem_wen_i,
  input  logic [REG_AW-1:0] wb_dst_i,
  input  logic              wb_wen_i,
  output logic              hold_o,
  output logic              bubble_o,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o
);

  localparam int unsigned NSRC = 2;

  logic [REG_AW-1:0] id_src [NSRC];
  logic              id_use [NSRC];
  logic [REG_AW-1:0] ex_src [NSRC];
  fwd_sel_e          sel    [NSRC];
  logic [NSRC-1:0]   src_hz;
  logic              data_hz;
  logic              br_hz;

  assign id_src[0] = id_src_a_i;
  assign id_src[1] = id_src_b_i;
  assign id_use[0] = id_use_a_i;
  assign id_use[1] = id_use_b_i;
  assign ex_src[0] = ex_src_a_i;
  assign ex_src[1] = ex_src_b_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    hz_src_check #(.REG_AW(REG_AW)) u_check (
      .fwd_en_i  (fwd_en_i),
      .src_i     (id_src[g]),
      .use_i     (id_use[g]),
      .ex_dst_i  (ex_dst_i),
      .ex_wen_i  (ex_wen_i),
      .ex_load_i (ex_load_i),
      .mem_dst_i (mem_dst_i),
      .mem_wen_i (mem_wen_i),
      .hazard_o  (src_hz[g])
    );

    hz_fwd_pick #(.REG_AW(REG_AW)) u_pick (
      .fwd_en_i  (fwd_en_i),
      .src_i     (ex_src[g]),
      .mem_dst_i (mem_dst_i),
      .mem_wen_i (mem_wen_i),
      .wb_dst_i  (wb_dst_i),
      .wb_wen_i  (wb_wen_i),
      .sel_o     (sel[g])
    );
  end

  assign data_hz = |src_hz;

  hz_branch_gate u_branch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .branch_i  (id_branch_i),
    .data_hz_i (data_hz),
    .br_hz_o   (br_hz)
  );

  assign hold_o   = data_hz || br_hz;
  assign bubble_o = hold_o;
  assign fwd_a_o  = sel[0];
  assign fwd_b_o  = sel[1];

endmodule

// File: rtl/hz_stall_ctrl_chk.sv
module hz_stall_ctrl_chk #(
  parameter int unsigned REG_AW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fwd_en_i,
  input logic [REG_AW-1:0] id_src_a_i,
  input logic              id_use_a_i,
  input logic              id_branch_i,
  input logic [REG_AW-1:0] ex_src_a_i,
  input logic [REG_AW-1:0] ex_dst_i,
  input logic              ex_wen_i,
  input logic              ex_load_i,
  input logic [REG_AW-1:0] mem_dst_i,
  input logic              mem_wen_i,
  input logic              hold_o,
  input logic              bubble_o,
  input logic [1:0]        fwd_a_o,
  input logic [1:0]        fwd_b_o
);

  a_r2_ex_producer_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwd_en_i && id_use_a_i && id_src_a_i != '0 && ex_wen_i && ex_dst_i == id_src_a_i)
    |-> hold_o);

  a_r3_wb_never_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ex_wen_i && !mem_wen_i && !id_branch_i) |-> !hold_o);

  a_r4_alu_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_en_i && !ex_load_i && !id_branch_i) |-> !hold_o);

  a_r5_zero_no_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_src_a_i == '0) |-> (fwd_a_o == 2'b00));

  a_r6_youngest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_en_i && mem_wen_i && mem_dst_i != '0 && mem_dst_i == ex_src_a_i)
    |-> (fwd_a_o == 2'b10));

  a_r7_no_bypass_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwd_en_i |-> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

  a_r8_branch_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_branch_i && hold_o && !ex_wen_i && !mem_wen_i)
    |=> !(id_branch_i && hold_o && !ex_wen_i && !mem_wen_i));

  a_r9_bubble_tracks_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o == hold_o);

endmodule

bind hz_stall_ctrl hz_stall_ctrl_chk #(.REG_AW(REG_AW)) u_hz_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fwd_en_i    (fwd_en_i),
  .id_src_a_i  (id_src_a_i),
  .id_use_a_i  (id_use_a_i),
  .id_branch_i (id_branch_i),
  .ex_src_a_i  (ex_src_a_i),
  .ex_dst_i    (ex_dst_i),
  .ex_wen_i    (ex_wen_i),
  .ex_load_i   (ex_load_i),
  .mem_dst_i   (mem_dst_i),
  .mem_wen_i   (mem_wen_i),
  .hold_o      (hold_o),
  .bubble_o    (bubble_o),
  .fwd_a_o     (fwd_a_o),
  .fwd_b_o     (fwd_b_o)
);

// File: tb/hz_stall_ctrl_tb_top.sv
module hz_stall_ctrl_tb_top;

  localparam int AW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          fwd_en_i;
  logic [AW-1:0] id_src_a_i, id_src_b_i;
  logic          id_use_a_i, id_use_b_i, id_branch_i;
  logic [AW-1:0] ex_src_a_i, ex_src_b_i, ex_dst_i;
  logic          ex_wen_i, ex_load_i;
  logic [AW-1:0] mem_dst_i, wb_dst_i;
  logic          mem_wen_i, wb_wen_i;
  logic          hold_o, bubble_o;
  logic [1:0]    fwd_a_o, fwd_b_o;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  hz_stall_ctrl #(.REG_AW(AW)) dut_i (.*);

  always #4 clk_i = ~clk_i;

  // Program: destination, sources, use flags, write, load, branch.
  int p_rd [10] = '{3, 4, 5, 4, 6, 4, 1, 2, 3, 0};
  int p_rs [10] = '{0, 0, 1, 4, 2, 4, 1, 2, 3, 3};
  int p_rt [10] = '{0, 0, 0, 5, 0, 6, 0, 0, 0, 0};
  bit p_ua [10] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 1};
  bit p_ub [10] = '{0, 1, 0, 1, 0, 1, 0, 0, 0, 1};
  bit p_we [10] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 0};
  bit p_ld [10] = '{0, 0, 1, 0, 1, 0, 0, 0, 0, 0};
  bit p_br [10] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    id_src_a_i = '0; id_src_b_i = '0; id_use_a_i = 0; id_use_b_i = 0;
    id_branch_i = 0; ex_src_a_i = '0; ex_src_b_i = '0; ex_dst_i = '0;
    ex_wen_i = 0; ex_load_i = 0; mem_dst_i = '0; mem_wen_i = 0;
    wb_dst_i = '0; wb_wen_i = 0;
  endtask

  task automatic step_in();
    @(posedge clk_i);
    #1;
    clear_inputs();
  endtask

  task automatic drive_stages(int id, int ex, int mem, int wb);
    clear_inputs();
    if (id >= 0) begin
      id_src_a_i = AW'(p_rs[id]); id_src_b_i = AW'(p_rt[id]);
      id_use_a_i = p_ua[id]; id_use_b_i = p_ub[id]; id_branch_i = p_br[id];
    end
    if (ex >= 0) begin
      ex_src_a_i = AW'(p_rs[ex]); ex_src_b_i = AW'(p_rt[ex]);
      ex_dst_i = AW'(p_rd[ex]); ex_wen_i = p_we[ex]; ex_load_i = p_ld[ex];
    end
    if (mem >= 0) begin
      mem_dst_i = AW'(p_rd[mem]); mem_wen_i = p_we[mem];
    end
    if (wb >= 0) begin
      wb_dst_i = AW'(p_rd[wb]); wb_wen_i = p_we[wb];
    end
  endtask

  // Driver pushes the expected stalled instructions; the monitor part of the
  // loop pops one per observed stall.
  task automatic run_prog(bit fwd, int exp_cycles);
    int id = 0, ex = -1, mem = -1, wb = -1, pc = 1, cyc = 0;
    bit done = 0;
    string tag = fwd ? "R10 bypass on" : "R10 bypass off";
    exp_q.delete();
    if (fwd) exp_q = '{3, 5, 9};
    else     exp_q = '{3, 3, 5, 5, 9, 9, 9};
    fwd_en_i = fwd;
    while (!done && cyc < 100) begin
      @(posedge clk_i);
      #1;
      drive_stages(id, ex, mem, wb);
      @(negedge clk_i);
      cyc++;
      if (hold_o) begin
        if (exp_q.size() == 0) check({tag, " unexpected stall"}, id, -1);
        else check({tag, " stalled instruction"}, id, exp_q.pop_front());
      end
      if (fwd && ex == 3) check("R6 load result via MEM/WB", fwd_b_o, 1);
      if (fwd && ex == 9) check("R6 ALU result via MEM/WB", fwd_a_o, 1);
      if (!fwd && ex >= 0) check("R7 selects idle", {fwd_a_o, fwd_b_o}, 0);
      if (wb == 9) done = 1;
      wb = mem;
      mem = ex;
      if (hold_o) begin
        ex = -1;
      end else begin
        ex = id;
        id = (pc < 10) ? pc : -1;
        pc++;
      end
    end
    check({tag, " missing stalls"}, exp_q.size(), 0);
    check({tag, " cycle count"}, cyc, exp_cycles);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 0;
    fwd_en_i = 0;
    clear_inputs();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;

    // R1 reset state
    @(negedge clk_i);
    check("R1 hold", hold_o, 0);
    check("R1 bubble", bubble_o, 0);
    check("R1 selects", {fwd_a_o, fwd_b_o}, 0);

    // R2 bypass off, producer in execute / memory
    step_in(); fwd_en_i = 0; id_src_a_i = 7; id_use_a_i = 1; ex_dst_i = 7; ex_wen_i = 1;
    @(negedge clk_i); check("R2 execute producer", hold_o, 1);
    check("R9 bubble with hold", bubble_o, 1);
    step_in(); id_src_b_i = 9; id_use_b_i = 1; mem_dst_i = 9; mem_wen_i = 1;
    @(negedge clk_i); check("R2 memory producer", hold_o, 1);
    step_in(); id_src_b_i = 9; id_use_b_i = 0; mem_dst_i = 9; mem_wen_i = 1;
    @(negedge clk_i); check("R2 unused source", hold_o, 0);

    // R3 writeback producer
    step_in(); id_src_a_i = 4; id_use_a_i = 1; wb_dst_i = 4; wb_wen_i = 1;
    @(negedge clk_i); check("R3 bypass off", hold_o, 0);
    step_in(); fwd_en_i = 1; id_src_a_i = 4; id_use_a_i = 1; wb_dst_i = 4; wb_wen_i = 1;
    @(negedge clk_i); check("R3 bypass on", hold_o, 0);
    check("R9 no bubble", bubble_o, 0);

    // R4 bypass on
    step_in(); id_src_a_i = 6; id_use_a_i = 1; ex_dst_i = 6; ex_wen_i = 1;
    @(negedge clk_i); check("R4 ALU producer", hold_o, 0);
    step_in(); id_src_b_i = 6; id_use_b_i = 1; ex_dst_i = 6; ex_wen_i = 1; ex_load_i = 1;
    @(negedge clk_i); check("R4 load-use", hold_o, 1);
    step_in(); id_src_a_i = 6; id_use_a_i = 1; mem_dst_i = 6; mem_wen_i = 1;
    @(negedge clk_i); check("R4 memory producer", hold_o, 0);

    // R5 register 0
    step_in(); fwd_en_i = 0; id_use_a_i = 1; id_use_b_i = 1; ex_wen_i = 1; mem_wen_i = 1;
    @(negedge clk_i); check("R5 zero stall", hold_o, 0);
    step_in(); fwd_en_i = 1; mem_wen_i = 1; wb_wen_i = 1;
    @(negedge clk_i); check("R5 zero bypass", {fwd_a_o, fwd_b_o}, 0);

    // R6 bypass selects and priority (2'b10 EX/MEM, 2'b01 MEM/WB)
    step_in(); ex_src_a_i = 3; ex_src_b_i = 8; mem_dst_i = 3; mem_wen_i = 1;
    wb_dst_i = 8; wb_wen_i = 1;
    @(negedge clk_i); check("R6 EX/MEM on A", fwd_a_o, 2);
    check("R6 MEM/WB on B", fwd_b_o, 1);
    step_in(); ex_src_a_i = 3; ex_src_b_i = 3; mem_dst_i = 3; mem_wen_i = 1;
    wb_dst_i = 3; wb_wen_i = 1;
    @(negedge clk_i); check("R6 youngest on A", fwd_a_o, 2);
    check("R6 youngest on B", fwd_b_o, 2);
    step_in(); ex_src_a_i = 3; mem_dst_i = 3; mem_wen_i = 0; wb_dst_i = 3; wb_wen_i = 1;
    @(negedge clk_i); check("R6 disabled writer skipped", fwd_a_o, 1);

    // R7 bypass off
    step_in(); fwd_en_i = 0; ex_src_a_i = 3; mem_dst_i = 3; mem_wen_i = 1;
    @(negedge clk_i); check("R7 selects zero", {fwd_a_o, fwd_b_o}, 0);

    // R8 branch alone
    step_in(); id_branch_i = 1;
    @(negedge clk_i); check("R8 branch first cycle", hold_o, 1);
    step_in(); id_branch_i = 1;
    @(negedge clk_i); check("R8 branch released", hold_o, 0);
    // R8 branch behind a data stall
    step_in(); id_branch_i = 1; id_src_a_i = 2; id_use_a_i = 1; ex_dst_i = 2; ex_wen_i = 1;
    @(negedge clk_i); check("R8 data stall first", hold_o, 1);
    step_in(); id_branch_i = 1; id_src_a_i = 2; id_use_a_i = 1;
    @(negedge clk_i); check("R8 then branch cycle", hold_o, 1);
    step_in(); id_branch_i = 1; id_src_a_i = 2; id_use_a_i = 1;
    @(negedge clk_i); check("R8 then released", hold_o, 0);
    step_in();
    @(negedge clk_i); check("R8 idle after branch", hold_o, 0);

    // R10 full sequence in both modes
    run_prog(0, 20);
    run_prog(1, 16);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule